// File: doc/BRIEF.md
# Serial Character Transmitter with Selectable Queue

This block turns host bytes into asynchronous serial characters. The host presents a byte with a one-cycle write strobe. The byte waits in a buffer until the shift stage is free. The shift stage then sends a start bit at logic 0, the data bits least significant first, an optional parity bit and one or two stop bits at logic 1. All bit timing is taken from a 16x baud enable pulse, so each serial bit spans sixteen enable pulses. Between characters the line rests at logic 1.

A mode input selects how deep the buffer is. In queued mode the buffer holds up to sixteen bytes. In single mode it behaves as one holding register. Two status outputs report how full the path is. One is high when the buffer is empty. The other is high only when the buffer is empty and the shift stage has nothing left to send. An interrupt request fires when the buffer drains, provided its enable input is set. The baud divisor, host bus decoding and modem lines are supplied elsewhere.

Top module: `txq_serializer`

## Requirements
- R1: With `fifo_mode`=1 the buffer stores up to 16 bytes. A write that arrives while 16 are stored is discarded, and the stored bytes are later sent unchanged and in order.
- R2: `hold_empty` is 1 exactly when the buffer holds no byte. It can fall only in the cycle after an accepted write.
- R3: `txe_irq` goes to 1 one cycle after the buffer passes from holding data to empty while `txe_ie`=1. A write strobe or `txe_ie`=0 clears it to 0. It is never 1 in the cycle after `txe_ie` was 0.
- R4: `all_empty` is 1 only when the buffer is empty and no character is being shifted. When it is 1, `tx_line` is 1.
- R5: Each serial bit lasts exactly 16 pulses of `tick16`, and `tx_line` changes only on a clock edge where `tick16` is 1.
- R6: A character is a 0 start bit, then N data bits LSB first, then stop bits at 1. N is 5, 6, 7 or 8 for `char_len` = 0, 1, 2 or 3. Data bits above N are not sent.
- R7: With `parity_en`=1 a parity bit follows the data bits. With `parity_odd`=0 the data bits plus the parity bit hold an even number of ones. With `parity_odd`=1 they hold an odd number.
- R8: `stop_two`=1 sends two stop bits and `stop_two`=0 sends one.
- R9: With `fifo_mode`=0 the buffer holds one byte. A second write while it is occupied is discarded.
- R10: When a byte is waiting at the end of the last stop bit, the next start bit follows with no idle time. Start bits of consecutive characters are then exactly 16 x (frame bits) ticks apart.
- R11: After reset `tx_line`=1, `hold_empty`=1, `all_empty`=1 and `txe_irq`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the baud rate |
| fifo_mode | input | 1 | 1: 16-deep queue, 0: single holding register |
| char_len | input | 2 | Data bits per character minus 5 |
| parity_en | input | 1 | Append a parity bit |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_two | input | 1 | 1: two stop bits, 0: one stop bit |
| txe_ie | input | 1 | Enable for the buffer-empty interrupt |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | DATA_W | Byte to transmit |
| tx_line | output | 1 | Serial output, idles at 1 |
| hold_empty | output | 1 | Buffer holds no byte |
| all_empty | output | 1 | Buffer empty and shift stage idle |
| txe_irq | output | 1 | Buffer-empty interrupt request |

## Verification
Two conditions are hard to reach from the ports: a full queue while a character is on the wire, and a byte waiting at the exact moment the last stop bit ends. The bench first sends one byte and waits until `hold_empty` rises. At that point the shift stage is busy, so the next sixteen back-to-back writes fill the queue and one more write tests the discard. Boundary timing is tested by loading three bytes with parity and two stop bits. A bench receiver timestamps each start edge and measures the start-to-start spacing against the expected frame length.

// File: rtl/txq_pkg.sv
package txq_pkg;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_START,
      SH_DATA,
      SH_PAR,
      SH_STOP
   } sh_state_t;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
   } frame_cfg_t;

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_one,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          empty,
   output logic [CW-1:0] count
);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, push, pop;

   assign empty = (count == '0);
   assign full  = cap_one ? !empty : (count == CW'(DEPTH));
   assign push  = wr_en && !full;
   assign pop   = rd_en && !empty;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/txq_shifter.sv
module txq_shifter
   import txq_pkg::*;
#(
   parameter int DW   = 8,
   parameter int TPB  = 16,
   localparam int TW  = $clog2(TPB),
   localparam int IW  = $clog2(DW),
   localparam int MINB = DW - 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  frame_cfg_t    cfg,
   input  logic          have_data,
   input  logic [DW-1:0] load_data,
   output logic          pop,
   output logic          idle,
   output logic          tx
);

   sh_state_t     state;
   logic [TW-1:0] tick_cnt;
   logic [IW-1:0] bit_idx, last_idx;
   logic [DW-1:0] shreg, mask, masked;
   logic [1:0]    len_q;
   logic          par_en_q, two_q, par_bit, stop_idx;
   logic          bit_end, last_stop, start_new;

   assign bit_end   = tick && (tick_cnt == TW'(TPB - 1));
   assign last_stop = !two_q || stop_idx;
   assign last_idx  = IW'(MINB - 1) + IW'(len_q);
   assign mask      = ~({DW{1'b1}} << (MINB + int'(cfg.len_sel)));
   assign masked    = load_data & mask;

   assign start_new = have_data &&
                      (((state == SH_IDLE) && tick) ||
                       ((state == SH_STOP) && bit_end && last_stop));
   assign pop  = start_new;
   assign idle = (state == SH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SH_IDLE;
         tick_cnt <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         len_q    <= '0;
         par_en_q <= 1'b0;
         two_q    <= 1'b0;
         par_bit  <= 1'b0;
         stop_idx <= 1'b0;
      end else if (start_new) begin
         state    <= SH_START;
         tick_cnt <= '0;
         bit_idx  <= '0;
         stop_idx <= 1'b0;
         shreg    <= masked;
         par_bit  <= (^masked) ^ cfg.par_odd;
         len_q    <= cfg.len_sel;
         par_en_q <= cfg.par_en;
         two_q    <= cfg.two_stop;
      end else if (state != SH_IDLE && tick) begin
         tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
         if (bit_end) begin
            case (state)
               SH_START: state <= SH_DATA;
               SH_DATA: begin
                  shreg <= shreg >> 1;
                  if (bit_idx == last_idx) begin
                     state    <= par_en_q ? SH_PAR : SH_STOP;
                     stop_idx <= 1'b0;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
               SH_PAR: begin
                  state    <= SH_STOP;
                  stop_idx <= 1'b0;
               end
               SH_STOP: begin
                  if (!last_stop) stop_idx <= 1'b1;
                  else            state    <= SH_IDLE;
               end
               default: state <= SH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         SH_START: tx = 1'b0;
         SH_DATA:  tx = shreg[0];
         SH_PAR:   tx = par_bit;
         default:  tx = 1'b1;
      endcase
   end

endmodule

// File: rtl/txq_irq.sv
module txq_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ie,
   input  logic buf_empty,
   input  logic wr_strobe,
   output logic irq
);

   logic empty_d;
   logic drained;

   assign drained = buf_empty && !empty_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_d <= 1'b1;
         irq     <= 1'b0;
      end else begin
         empty_d <= buf_empty;
         if (!ie || wr_strobe) irq <= 1'b0;
         else if (drained)     irq <= 1'b1;
      end
   end

endmodule

// File: rtl/txq_serializer.sv
module txq_serializer
   import txq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FIFO_DEPTH = 16,
   parameter int TICKS_BIT  = 16,
   localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              fifo_mode,
   input  logic [1:0]        char_len,
   input  logic              parity_en,
   input  logic              parity_odd,
   input  logic              stop_two,
   input  logic              txe_ie,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_line,
   output logic              hold_empty,
   output logic              all_empty,
   output logic              txe_irq
);

   generate
      if (DATA_W < 5) begin : g_bad_width
         $error("DATA_W must be at least 5");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (TICKS_BIT < 2) begin : g_bad_ticks
         $error("TICKS_BIT must be at least 2");
      end
   endgenerate

   frame_cfg_t        cfg;
   logic [DATA_W-1:0] head_data;
   logic [CNT_W-1:0]  fifo_count;
   logic              buf_empty, pop, sh_idle;

   assign cfg = '{len_sel: char_len, par_en: parity_en,
                  par_odd: parity_odd, two_stop: stop_two};

   txq_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_one (!fifo_mode),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (pop),
      .rd_data (head_data),
      .empty   (buf_empty),
      .count   (fifo_count)
   );

   txq_shifter #(.DW(DATA_W), .TPB(TICKS_BIT)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick16),
      .cfg       (cfg),
      .have_data (!buf_empty),
      .load_data (head_data),
      .pop       (pop),
      .idle      (sh_idle),
      .tx        (tx_line)
   );

   txq_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ie        (txe_ie),
      .buf_empty (buf_empty),
      .wr_strobe (wr_en),
      .irq       (txe_irq)
   );

   assign hold_empty = buf_empty;
   assign all_empty  = buf_empty && sh_idle;

endmodule

// File: rtl/txq_serializer_chk.sv
module txq_serializer_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick16,
   input logic          wr_en,
   input logic          txe_ie,
   input logic          tx_line,
   input logic          hold_empty,
   input logic          all_empty,
   input logic          txe_irq,
   input logic [CW-1:0] fifo_count
);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= CW'(DEPTH)); // R1

   AST_FILL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_empty) |-> $past(wr_en)); // R2

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !txe_ie |=> !txe_irq); // R3

   AST_ALL_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      all_empty |-> (hold_empty && tx_line)); // R4

   AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_line != $past(tx_line)) |-> $past(tick16)); // R5

endmodule

bind txq_serializer txq_serializer_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick16     (tick16),
   .wr_en      (wr_en),
   .txe_ie     (txe_ie),
   .tx_line    (tx_line),
   .hold_empty (hold_empty),
   .all_empty  (all_empty),
   .txe_irq    (txe_irq),
   .fifo_count (fifo_count)
);

// File: tb/txq_serializer_tb.sv
`timescale 1ns/1ps
module txq_serializer_tb;

   localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       fifo_mode = 1'b1;
   logic [1:0] char_len = 2'd3;
   logic       parity_en = 1'b0;
   logic       parity_odd = 1'b0;
   logic       stop_two = 1'b0;
   logic       txe_ie = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       tx_line, hold_empty, all_empty, txe_irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [7:0] rx_data_q[$];
   logic       rx_par_q[$];
   logic       rx_ok_q[$];
   int         rx_t_q[$];

   txq_serializer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .fifo_mode  (fifo_mode),
      .char_len   (char_len),
      .parity_en  (parity_en),
      .parity_odd (parity_odd),
      .stop_two   (stop_two),
      .txe_ie     (txe_ie),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .tx_line    (tx_line),
      .hold_empty (hold_empty),
      .all_empty  (all_empty),
      .txe_irq    (txe_irq)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) tick16 <= ~tick16;

   // Serial receiver sampling at mid-bit
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_line == 1'b0) begin
            int t0;
            int nb;
            logic [7:0] d;
            logic ok, p;
            t0 = cyc;
            nb = 5 + int'(char_len);
            d  = '0;
            p  = 1'b0;
            repeat (BITCLK/2) @(negedge clk);
            ok = (tx_line == 1'b0);
            for (int i = 0; i < nb; i++) begin
               repeat (BITCLK) @(negedge clk);
               d[i] = tx_line;
            end
            if (parity_en) begin
               repeat (BITCLK) @(negedge clk);
               p = tx_line;
            end
            repeat (BITCLK) @(negedge clk);
            ok = ok && tx_line;
            if (stop_two) begin
               repeat (BITCLK) @(negedge clk);
               ok = ok && tx_line;
            end
            rx_data_q.push_back(d);
            rx_par_q.push_back(p);
            rx_ok_q.push_back(ok);
            rx_t_q.push_back(t0);
         end
      end
   end

   task automatic check(input bit cond, input string req, input int act, input int exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!all_empty);
      repeat (3*BITCLK) @(negedge clk);
   endtask

   task automatic clear_rx();
      rx_data_q.delete();
      rx_par_q.delete();
      rx_ok_q.delete();
      rx_t_q.delete();
   endtask

   task automatic expect_frame(input logic [7:0] exp, input string req);
      if (rx_data_q.size() == 0) begin
         check(1'b0, req, 0, 1);
      end else begin
         logic [7:0] d;
         logic ok;
         d  = rx_data_q.pop_front();
         ok = rx_ok_q.pop_front();
         check(d == exp, req, d, exp);
         check(ok, {req, " framing"}, ok, 1);
      end
   endtask

   task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po, input logic two);
      @(negedge clk);
      char_len = len; parity_en = pe; parity_odd = po; stop_two = two;
   endtask

   task automatic t_reset();
      check(tx_line == 1'b1, "R11 line", tx_line, 1);
      check(hold_empty == 1'b1, "R11 hold_empty", hold_empty, 1);
      check(all_empty == 1'b1, "R11 all_empty", all_empty, 1);
      check(txe_irq == 1'b0, "R11 irq", txe_irq, 0);
   endtask

   task automatic t_basic();
      clear_rx();
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
      write_byte(8'hA5);
      repeat (10) @(negedge clk);
      check(hold_empty == 1'b1, "R2 popped", hold_empty, 1);
      check(all_empty == 1'b0, "R4 busy", all_empty, 0);
      wait_idle();
      check(rx_data_q.size() == 1, "R6 count", rx_data_q.size(), 1);
      expect_frame(8'hA5, "R6 8-bit data");
   endtask

   task automatic t_lengths();
      for (int len = 0; len < 3; len++) begin
         clear_rx();
         set_cfg(2'(len), 1'b0, 1'b0, 1'b0);
         write_byte(8'hD6);
         wait_idle();
         expect_frame(8'hD6 & 8'((1 << (5 + len)) - 1), "R6 short length");
      end
   endtask

   task automatic t_parity();
      logic p;
      clear_rx();
      set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
      write_byte(8'h07);
      wait_idle();
      p = rx_par_q.size() > 0 ? rx_par_q[0] : 1'bx;
      check(p === 1'b1, "R7 even parity 3 ones", p, 1);
      expect_frame(8'h07, "R7 data");
      clear_rx();
      set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
      write_byte(8'h07);
      wait_idle();
      p = rx_par_q.size() > 0 ? rx_par_q[0] : 1'bx;
      check(p === 1'b0, "R7 odd parity 3 ones", p, 0);
      expect_frame(8'h07, "R7 data odd");
   endtask

   task automatic t_back2back();
      clear_rx();
      fifo_mode = 1'b1;
      set_cfg(2'd3, 1'b1, 1'b0, 1'b1);
      write_byte(8'h3C);
      write_byte(8'hC3);
      write_byte(8'h81);
      wait_idle();
      check(rx_t_q.size() == 3, "R10 frames", rx_t_q.size(), 3);
      if (rx_t_q.size() == 3) begin
         check(rx_t_q[1] - rx_t_q[0] == 12*BITCLK, "R10 R8 R5 spacing 1", rx_t_q[1] - rx_t_q[0], 12*BITCLK);
         check(rx_t_q[2] - rx_t_q[1] == 12*BITCLK, "R10 R8 spacing 2", rx_t_q[2] - rx_t_q[1], 12*BITCLK);
      end
      expect_frame(8'h3C, "R10 first");
      expect_frame(8'hC3, "R10 second");
      expect_frame(8'h81, "R10 third");
   endtask

   task automatic t_fifo_full();
      clear_rx();
      fifo_mode = 1'b1;
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
      write_byte(8'h00);
      do @(negedge clk); while (!hold_empty);
      @(negedge clk);
      wr_en = 1'b1;
      for (int i = 1; i <= 17; i++) begin
         wr_data = (i == 17) ? 8'hEE : 8'(i);
         @(negedge clk);
      end
      wr_en = 1'b0;
      check(hold_empty == 1'b0, "R2 filled", hold_empty, 0);
      wait_idle();
      check(rx_data_q.size() == 17, "R1 frame count", rx_data_q.size(), 17);
      expect_frame(8'h00, "R1 head");
      for (int i = 1; i <= 16; i++) expect_frame(8'(i), "R1 stored entry");
   endtask

   task automatic t_nonfifo();
      clear_rx();
      fifo_mode = 1'b0;
      set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
      write_byte(8'h11);
      do @(negedge clk); while (!hold_empty);
      write_byte(8'h22);
      check(hold_empty == 1'b0, "R9 holding occupied", hold_empty, 0);
      write_byte(8'h33);
      wait_idle();
      check(rx_data_q.size() == 2, "R9 frame count", rx_data_q.size(), 2);
      expect_frame(8'h11, "R9 first");
      expect_frame(8'h22, "R9 second");
      fifo_mode = 1'b1;
   endtask

   task automatic t_irq();
      clear_rx();
      @(negedge clk);
      txe_ie = 1'b1;
      write_byte(8'h5A);
      do @(negedge clk); while (!hold_empty);
      repeat (2) @(negedge clk);
      check(txe_irq == 1'b1, "R3 raised on drain", txe_irq, 1);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h6B;
      @(negedge clk);
      wr_en = 1'b0;
      check(txe_irq == 1'b0, "R3 cleared by write", txe_irq, 0);
      do @(negedge clk); while (!hold_empty);
      repeat (2) @(negedge clk);
      check(txe_irq == 1'b1, "R3 raised again", txe_irq, 1);
      txe_ie = 1'b0;
      repeat (2) @(negedge clk);
      check(txe_irq == 1'b0, "R3 cleared by disable", txe_irq, 0);
      wait_idle();
      write_byte(8'h7C);
      do @(negedge clk); while (!hold_empty);
      repeat (4) @(negedge clk);
      check(txe_irq == 1'b0, "R3 masked", txe_irq, 0);
      wait_idle();
      expect_frame(8'h5A, "R3 data a");
      expect_frame(8'h6B, "R3 data b");
      expect_frame(8'h7C, "R3 data c");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic();
      t_lengths();
      t_parity();
      t_back2back();
      t_fifo_full();
      t_nonfifo();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule